// File: doc/BRIEF.md
# Interleaved 64-bit VRAM stream writer

This block sits between a byte-addressed 32-bit host port and an 8 MB video memory made of two 32-bit banks of 1 M words each. In the 64-bit view of that memory, neighbouring 32-bit words live in opposite banks. Byte address bit 2 chooses the bank. Bits 22..3 form the word address inside the bank. Bits 1..0 pick the byte lane. A combinational port applies this mapping to any single address, so a one-beat read path can use it.

The main job is streaming writes. A `start` pulse loads a byte address and a byte length. The block then takes one 32-bit beat per memory word over a valid/ready input and issues one byte-enabled write per beat, switching banks on every word. A ragged first word and a ragged last word are written with partial byte enables instead of read-modify-write. Input bytes use little-endian packing and sit in their destination lanes: stream byte k lands in lane (start + k) mod 4 of its beat. The transfer is cut short so that it never passes the top of the 8 MB space. A one-cycle `done` pulse marks the end.

Back-pressure: `in_ready` is high for exactly the cycles in which a transfer is open. A beat is taken on any rising edge where both `in_valid` and `in_ready` are high. The source may drop `in_valid` at any time to stall. The memory write port is assumed to accept a write on every cycle.

Top module: `v64_stream_writer`

## Requirements
- R1: `xlat_phys` equals {a[2], a[22:3], a[1:0]}, where a is `xlat_addr`. Bit 23 of `xlat_addr` has no effect.
- R2: Only bits 22..0 of `start_addr` are used, so bit 23 has no effect. A `start` that arrives while a transfer is open is ignored.
- R3: When the masked start address plus the length passes 0x800000, the length is cut to 0x800000 minus the start address.
- R4: Let w be (masked start >> 2) + n for beat n. Beat n is written to bank w[0] at word address w >> 1. As a result the banks alternate on every beat, and the first bank is start bit 2.
- R5: The first beat enables lanes from start[1:0] up to lane 3, or fewer if the length runs out first.
- R6: Every beat other than the first and the last has all four byte enables set (`mem_be` = 4'b1111).
- R7: When the last beat is not also the first, it enables only the lowest (remaining bytes) lanes, starting at lane 0.
- R8: `in_ready` is high exactly while a transfer is open. Each accepted beat gives exactly one write, in the next cycle, with `mem_wdata` equal to the accepted `in_data`. No write happens without an accepted beat.
- R9: `done` pulses for one cycle together with the last write. If the length is zero, `done` pulses in the cycle after `start` and no write is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (honoured only when idle) |
| start_addr | input | 24 | Byte start address in the 64-bit view |
| start_len | input | 24 | Transfer length in bytes |
| in_data | input | 32 | Beat data, bytes in destination lanes |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken (transfer open) |
| mem_we | output | 1 | Memory write strobe |
| mem_bank | output | 1 | Target bank |
| mem_waddr | output | 20 | Word address within the bank |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit i for lane i |
| done | output | 1 | Transfer finished (one cycle) |
| xlat_addr | input | 24 | Address for single-beat translation |
| xlat_phys | output | 23 | Physical byte address {bank, word, lane} |

## Verification
The translation port is combinational, so its result is checked one time step after the address changes, with no clock edge in between. A write, together with its bank, word address, enables and data, is due on the clock edge that follows the edge that accepted the beat. `done` is due on that same edge for the last beat, or on the edge after `start` when the length is zero. The reference model in the bench reads the handshake and `start` at each falling edge and queues what the design must show after the next rising edge. It then compares every output at the following falling edge, so each result is sampled exactly one register stage after its cause.

// File: rtl/v64_pkg.sv
package v64_pkg;
  localparam int unsigned HOST_AW = 24;               // host byte address width
  localparam int unsigned MEM_AW  = 23;               // 8 MB physical space
  localparam int unsigned LEN_W   = 24;               // byte length width
  localparam int unsigned DW      = 32;               // beat / bank word width
  localparam int unsigned LANES   = DW / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);    // lane index width
  localparam int unsigned WORD_W  = MEM_AW - OFF_W;   // 32-bit word index width
  localparam int unsigned BANK_AW = WORD_W - 1;       // word address inside one bank

  typedef struct packed {
    logic               bank;
    logic [BANK_AW-1:0] waddr;
    logic [OFF_W-1:0]   lane;
  } phys_t;
endpackage

// File: rtl/v64_addr_xlat.sv
module v64_addr_xlat
  import v64_pkg::*;
(
  input  logic [MEM_AW-1:0] byte_addr,
  output phys_t             phys
);
  // the bit just above the lane index picks the bank; the rest shifts down one
  always_comb begin
    phys.bank  = byte_addr[OFF_W];
    phys.waddr = byte_addr[MEM_AW-1:OFF_W+1];
    phys.lane  = byte_addr[OFF_W-1:0];
  end
endmodule

// File: rtl/v64_span_clamp.sv
module v64_span_clamp
  import v64_pkg::*;
(
  input  logic [MEM_AW-1:0] base,
  input  logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  eff_len
);
  localparam logic [LEN_W-1:0] SPACE_TOP = LEN_W'(1) << MEM_AW;

  logic [LEN_W-1:0] room;

  always_comb begin
    room    = SPACE_TOP - {{(LEN_W-MEM_AW){1'b0}}, base};
    eff_len = (req_len > room) ? room : req_len;
  end
endmodule

// File: rtl/v64_lane_plan.sv
module v64_lane_plan
  import v64_pkg::*;
(
  input  logic [OFF_W-1:0] lo,
  input  logic [LEN_W-1:0] rem,
  output logic [LANES-1:0] be,
  output logic [OFF_W:0]   nbytes,
  output logic             last
);
  logic [OFF_W:0] avail;
  logic [OFF_W:0] hi_ex;

  always_comb begin
    avail  = (OFF_W+1)'(LANES) - {1'b0, lo};
    last   = rem <= {{(LEN_W-OFF_W-1){1'b0}}, avail};
    nbytes = last ? rem[OFF_W:0] : avail;
    hi_ex  = {1'b0, lo} + nbytes;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = ({1'b0, lo} <= (OFF_W+1)'(g)) && ((OFF_W+1)'(g) < hi_ex);
  end
endmodule

// File: rtl/v64_stream_writer.sv
module v64_stream_writer
  import v64_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [HOST_AW-1:0] start_addr,
  input  logic [LEN_W-1:0]   start_len,
  input  logic [DW-1:0]      in_data,
  input  logic               in_valid,
  output logic               in_ready,
  output logic               mem_we,
  output logic               mem_bank,
  output logic [BANK_AW-1:0] mem_waddr,
  output logic [DW-1:0]      mem_wdata,
  output logic [LANES-1:0]   mem_be,
  output logic               done,
  input  logic [HOST_AW-1:0] xlat_addr,
  output logic [MEM_AW-1:0]  xlat_phys
);
  logic [MEM_AW-1:0] base_masked;
  logic [LEN_W-1:0]  len_eff;
  logic              active;
  logic [WORD_W-1:0] wptr;
  logic [OFF_W-1:0]  lo;
  logic [LEN_W-1:0]  rem;
  logic [LANES-1:0]  beat_be;
  logic [OFF_W:0]    beat_n;
  logic              beat_last;
  phys_t             xlat_res;
  logic              unused_hi;

  assign base_masked = start_addr[MEM_AW-1:0];
  assign unused_hi   = ^{start_addr[HOST_AW-1:MEM_AW], xlat_addr[HOST_AW-1:MEM_AW]};

  v64_addr_xlat u_xlat (
    .byte_addr (xlat_addr[MEM_AW-1:0]),
    .phys      (xlat_res)
  );
  assign xlat_phys = xlat_res;

  v64_span_clamp u_clamp (
    .base    (base_masked),
    .req_len (start_len),
    .eff_len (len_eff)
  );

  v64_lane_plan u_plan (
    .lo     (lo),
    .rem    (rem),
    .be     (beat_be),
    .nbytes (beat_n),
    .last   (beat_last)
  );

  assign in_ready = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      wptr      <= '0;
      lo        <= '0;
      rem       <= '0;
      mem_we    <= 1'b0;
      mem_bank  <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      done      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      if (active) begin
        if (in_valid) begin
          mem_we    <= 1'b1;
          mem_bank  <= wptr[0];
          mem_waddr <= wptr[WORD_W-1:1];
          mem_wdata <= in_data;
          mem_be    <= beat_be;
          wptr      <= wptr + WORD_W'(1);
          lo        <= '0;
          rem       <= rem - LEN_W'(beat_n);
          if (beat_last) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end else if (start) begin
        if (len_eff == '0) begin
          done <= 1'b1;
        end else begin
          active <= 1'b1;
          wptr   <= base_masked[MEM_AW-1:OFF_W];
          lo     <= base_masked[OFF_W-1:0];
          rem    <= len_eff;
        end
      end
    end
  end
endmodule

// File: rtl/v64_stream_writer_chk.sv
module v64_stream_writer_chk
  import v64_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               mem_we,
  input logic               mem_bank,
  input logic [BANK_AW-1:0] mem_waddr,
  input logic [LANES-1:0]   mem_be,
  input logic               done
);
  logic               seen;
  logic               prev_bank;
  logic [BANK_AW-1:0] prev_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= 1'b0;
      prev_bank  <= 1'b0;
      prev_waddr <= '0;
    end else if (done) begin
      seen <= 1'b0;
    end else if (mem_we) begin
      seen       <= 1'b1;
      prev_bank  <= mem_bank;
      prev_waddr <= mem_waddr;
    end
  end

  AST_WRITE_HAS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(in_valid && in_ready)); // R8
  AST_BEAT_GIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> mem_we); // R8
  AST_READY_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready); // R9
  AST_BANK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && seen) |-> (mem_bank != prev_bank)); // R4
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && seen) |-> (mem_waddr == (mem_bank ? prev_waddr : prev_waddr + BANK_AW'(1)))); // R4
  AST_LATER_FROM_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && seen) |-> mem_be[0]); // R7
  AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) >= 1)); // R5
endmodule

bind v64_stream_writer v64_stream_writer_chk u_chk (.*);

// File: tb/v64_stream_writer_tb.sv
module v64_stream_writer_tb;
  import v64_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [HOST_AW-1:0] start_addr = '0;
  logic [LEN_W-1:0]   start_len = '0;
  logic [DW-1:0]      in_data = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic               mem_we;
  logic               mem_bank;
  logic [BANK_AW-1:0] mem_waddr;
  logic [DW-1:0]      mem_wdata;
  logic [LANES-1:0]   mem_be;
  logic               done;
  logic [HOST_AW-1:0] xlat_addr = '0;
  logic [MEM_AW-1:0]  xlat_phys;

  v64_stream_writer u_dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    int unsigned bank;
    int unsigned waddr;
    int unsigned be;
    bit          last;
  } beat_t;

  beat_t       q[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          m_active = 0;
  bit          e_we = 0, e_done = 0;
  int unsigned e_bank = 0, e_waddr = 0, e_be = 0;
  logic [31:0] e_data = '0;
  logic [31:0] seed = 32'h1234_5678;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // byte-level expectation of the beats for one transfer
  task automatic plan(input int unsigned addr, input int unsigned len);
    int unsigned a, room, l, cur;
    beat_t b;
    bit have;
    a    = addr & 32'h7F_FFFF;              // R2 mask
    room = 32'h80_0000 - a;
    l    = (len > room) ? room : len;       // R3 clamp
    q.delete();
    have = 0;
    cur  = 0;
    b    = '{0, 0, 0, 0};
    for (int unsigned k = 0; k < l; k++) begin
      int unsigned p, w;
      p = a + k;
      w = p >> 2;
      if (!have || w != cur) begin
        if (have) q.push_back(b);
        b.bank = w & 1; b.waddr = w >> 1; b.be = 0; b.last = 0;
        cur = w; have = 1;
      end
      b.be = b.be | (1 << (p & 3));
    end
    if (have) begin
      b.last = 1;
      q.push_back(b);
    end
  endtask

  // per-cycle reference model: compare, then predict the next edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready === m_active, "R8", "in_ready", longint'(in_ready), longint'(m_active));
      chk(mem_we === e_we, "R8", "mem_we", longint'(mem_we), longint'(e_we));
      if (e_we) begin
        chk(mem_bank === e_bank[0], "R4", "mem_bank", longint'(mem_bank), longint'(e_bank));
        chk(mem_waddr === e_waddr[BANK_AW-1:0], "R4", "mem_waddr", longint'(mem_waddr), longint'(e_waddr));
        chk(mem_be === e_be[3:0], "R5/R6/R7", "mem_be", longint'(mem_be), longint'(e_be));
        chk(mem_wdata === e_data, "R8", "mem_wdata", longint'(mem_wdata), longint'(e_data));
      end
      chk(done === e_done, "R9", "done", longint'(done), longint'(e_done));
      e_we = 0;
      e_done = 0;
      if (m_active) begin
        if (in_valid && q.size() > 0) begin
          beat_t b;
          b = q.pop_front();
          e_we = 1; e_bank = b.bank; e_waddr = b.waddr; e_be = b.be; e_data = in_data;
          if (b.last) begin
            m_active = 0;
            e_done = 1;
          end
        end
      end else if (start) begin
        plan(start_addr, start_len);
        if (q.size() == 0) e_done = 1;
        else m_active = 1;
      end
    end
  end

  task automatic run(input int unsigned addr, input int unsigned len,
                     input bit stall, input bit mid_start);
    int cyc;
    @(posedge clk); #1;
    start = 1; start_addr = addr[HOST_AW-1:0]; start_len = len[LEN_W-1:0];
    @(posedge clk); #1;
    start = 0;
    cyc = 0;
    while (!done) begin
      in_valid = stall ? (cyc % 3 != 1) : 1'b1;
      seed = seed * 32'd1664525 + 32'd1013904223;
      in_data = seed;
      if (mid_start && cyc == 2) begin   // R2: ignored while open
        start = 1; start_addr = 24'h000100; start_len = 24'd8;
      end else begin
        start = 0;
      end
      cyc++;
      @(posedge clk); #1;
    end
    in_valid = 0;
    start = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic xchk(input int unsigned addr);
    int unsigned a, exp;
    xlat_addr = addr[HOST_AW-1:0];
    #1;
    a   = addr & 32'h7F_FFFF;
    exp = ((a & 32'hFF_FFF8) >> 1) | ((a & 32'h4) << 20) | (a & 32'h3);
    chk(xlat_phys === exp[MEM_AW-1:0], "R1", "xlat_phys", longint'(xlat_phys), longint'(exp));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL R9 watchdog: done actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0, "R8", "reset in_ready", longint'(in_ready), 0);
    chk(mem_we === 1'b0, "R8", "reset mem_we", longint'(mem_we), 0);
    chk(done === 1'b0, "R9", "reset done", longint'(done), 0);
    @(posedge clk); #1;
    rst_n = 1;

    // R1 single-address translation, including bit 23 set
    xchk(32'h00_0000);
    xchk(32'h00_0004);
    xchk(32'h00_0013);
    xchk(32'h7F_FFFF);
    xchk(32'h85_5AAE);

    run(32'h00_0040, 16, 0, 0);   // R4 R6 aligned, starts in bank 0
    run(32'h00_0104, 12, 0, 0);   // R4 starts in bank 1
    run(32'h00_0201, 9, 0, 0);    // R5 R7 ragged head and tail
    run(32'h00_0303, 1, 0, 0);    // R5 one byte in lane 3
    run(32'h00_0402, 1, 0, 0);    // R5 head cut short by length
    run(32'h00_0500, 0, 0, 0);    // R9 zero length
    run(32'h7F_FFFA, 100, 0, 0);  // R3 clamp at top of space
    run(32'h80_0010, 8, 0, 0);    // R2 bit 23 ignored
    run(32'h00_0600, 32, 1, 0);   // R8 full burst with stalls
    run(32'h00_0705, 40, 0, 1);   // R2 start while open is ignored
    run(32'h00_0807, 6, 1, 0);    // R5 R7 ragged with stalls
    run(32'h00_0900, 0, 0, 0);    // R9 zero length again
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule